// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch Memory

This block is the internal data store of a small 8-bit controller core. It holds 256 bytes of RAM and a separate 128-byte window of special-function registers (SFRs). The lower 32 bytes of RAM also act as four banks of eight working registers. A 2-bit bank select picks which bank the working-register port sees. A 16-byte area just above the banks, and a subset of the SFRs, can be read and changed one bit at a time.

Three access ports share one internal path. Only one port is active in a given cycle.
- The byte port carries a direct/indirect flag. For addresses 80h and above, a direct access reaches the SFR window and an indirect access reaches the upper 128 bytes of RAM.
- The working-register port takes a register index and a bank select.
- The bit port takes a bit address, a 3-bit operation code and a carry-style input bit. It returns the old value of the addressed bit. For operations that modify the bit, it rewrites the containing byte in the same cycle.

Reads are combinational from the stored state. Writes take effect at the next rising clock edge.

Top module: `bitram_unit`

## Requirements
- R1: While reset is held, every RAM byte and every SFR byte is cleared to 00h. After reset, all reads return 00h until something is written.
- R2: The working-register port reaches the byte at address 8*bank + index. The bank is bankSel, with bankSel[1] as the most significant bit, so banks 0 to 3 start at 00h, 08h, 10h and 18h.
- R3: Every byte used as a working register is also reachable through the byte port at its absolute address, in direct or indirect mode, whatever value bankSel holds.
- R4: On the byte port, addresses 00h to 7Fh reach the same RAM in both modes. Addresses 80h to FFh reach the SFR window when byteInd=0 and the upper RAM when byteInd=1. The two are separate storage.
- R5: Bit address a in 00h to 7Fh names bit (a mod 8) of RAM byte 20h + (a div 8). The bytes 20h to 2Fh stay readable and writable as whole bytes.
- R6: Bit address a in 80h to FFh names bit (a mod 8) of the SFR at byte address (a AND F8h).
- R7: bitOp encodings:
  - 0: read only.
  - 1: bit := bit OR bitIn.
  - 2: bit := bit AND bitIn.
  - 3: bit := bit XOR bitIn.
  - 4: complement the bit.
  - 5: set the bit.
  - 6: bit := bitIn.
  - 7: test-and-clear, which clears the bit only if it was 1.
  
  For every operation, bitOut shows the bit's value before the operation.
- R8: A bit write changes only the addressed bit. It is a read-modify-write of the containing byte done within one clock cycle. The new value is readable in the following cycle.
- R9: An SFR slot whose bit in SFR_BIT_MASK is 0 is not bit-addressable. The slot index is (a AND 78h)/8, and the default mask 7FFFh leaves only F8h out. A bit access to such a slot gives bitOut=0 and leaves the byte unchanged.
- R10: Each read-data output shows the addressed byte in the same cycle its port's enable is high, and shows 00h while that enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| byteEn | input | 1 | Byte port access this cycle |
| byteWe | input | 1 | Byte port writes byteWdata |
| byteInd | input | 1 | 1 = indirect mode, 0 = direct mode |
| byteAddr | input | 8 | Byte address |
| byteWdata | input | 8 | Byte write data |
| byteRdata | output | 8 | Byte read data |
| regEn | input | 1 | Working-register port access |
| regWe | input | 1 | Working-register write |
| regIdx | input | 3 | Register index inside the bank |
| bankSel | input | 2 | Active bank number |
| regWdata | input | 8 | Working-register write data |
| regRdata | output | 8 | Working-register read data |
| bitEn | input | 1 | Bit port access |
| bitOp | input | 3 | Bit operation code |
| bitAddr | input | 8 | Bit address |
| bitIn | input | 1 | Operand bit |
| bitOut | output | 1 | Old value of the addressed bit |

## Verification
The assertions assume that at most one of byteEn, regEn and bitEn is high in any cycle. They also assume that a write port's data is stable for the whole cycle it is enabled. The stimulus drives each access from a single task, which lowers all three enables before raising one, so no cycle ever has two ports active.

The vectors are chosen so that the same byte is reached through different ports. They cover:
- working-register addresses read back through the byte port, in both modes;
- one upper address written in both modes and read back in both modes;
- bit operations that land on bits already holding the value being written;
- a bit access to the one SFR slot that is not bit-addressable.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_OR     = 3'd1,
    OP_AND    = 3'd2,
    OP_XOR    = 3'd3,
    OP_CPL    = 3'd4,
    OP_SET    = 3'd5,
    OP_MOV    = 3'd6,
    OP_TSTCLR = 3'd7
  } bitOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic              toSfr;
    logic              isBit;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  bitIdx;
    logic              newBit;
    logic [DATA_W-1:0] wdata;
  } memStrobeT;
endpackage

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
  import bitram_pkg::*;
#(
  parameter int          BANK_SEL_W   = 2,
  parameter int          REG_IDX_W    = 3,
  parameter logic [7:0]  BIT_AREA     = 8'h20,
  parameter logic [15:0] SFR_BIT_MASK = 16'h7FFF
) (
  input  logic                  byteEn,
  input  logic                  byteWe,
  input  logic                  byteInd,
  input  logic [ADDR_W-1:0]     byteAddr,
  input  logic [DATA_W-1:0]     byteWdata,
  input  logic                  regEn,
  input  logic                  regWe,
  input  logic [REG_IDX_W-1:0]  regIdx,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic                  bitEn,
  input  logic [2:0]            bitOp,
  input  logic [ADDR_W-1:0]     bitAddr,
  input  logic                  bitIn,
  input  logic                  oldBit,
  output memStrobeT             strobe,
  output logic                  bitOk
);
  localparam int SLOT_W = ADDR_W - IDX_W - 1;

  logic [SLOT_W-1:0] slot;
  logic              opWrites;
  logic              nb;

  assign slot = bitAddr[ADDR_W-2:IDX_W];

  always_comb begin
    nb = oldBit;
    opWrites = 1'b1;
    unique case (bitOpE'(bitOp))
      OP_READ:   opWrites = 1'b0;
      OP_OR:     nb = oldBit | bitIn;
      OP_AND:    nb = oldBit & bitIn;
      OP_XOR:    nb = oldBit ^ bitIn;
      OP_CPL:    nb = ~oldBit;
      OP_SET:    nb = 1'b1;
      OP_MOV:    nb = bitIn;
      OP_TSTCLR: begin nb = 1'b0; opWrites = oldBit; end
      default:   opWrites = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    bitOk  = 1'b0;
    if (bitEn) begin
      strobe.isBit  = 1'b1;
      strobe.bitIdx = bitAddr[IDX_W-1:0];
      strobe.newBit = nb;
      if (!bitAddr[ADDR_W-1]) begin
        strobe.addr = BIT_AREA + ADDR_W'(slot);
        bitOk       = 1'b1;
      end else begin
        strobe.addr  = {bitAddr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        strobe.toSfr = 1'b1;
        bitOk        = SFR_BIT_MASK[slot];
      end
      strobe.wr = opWrites && bitOk;
    end else if (regEn) begin
      strobe.addr  = ADDR_W'({bankSel, regIdx});
      strobe.wr    = regWe;
      strobe.wdata = regWdata;
    end else if (byteEn) begin
      strobe.addr  = byteAddr;
      strobe.toSfr = !byteInd && byteAddr[ADDR_W-1];
      strobe.wr    = byteWe;
      strobe.wdata = byteWdata;
    end
  end
endmodule

// File: rtl/bitram_dp.sv
module bitram_dp
  import bitram_pkg::*;
#(
  parameter int          RAM_BYTES    = 256,
  parameter int          SFR_BYTES    = 128,
  parameter logic [15:0] SFR_BIT_MASK = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobeT         strobe,
  output logic [DATA_W-1:0] rdByte,
  output logic              oldBit
);
  localparam int SFR_IDX_W = $clog2(SFR_BYTES);

  logic [DATA_W-1:0] ram [RAM_BYTES];
  logic [DATA_W-1:0] sfr [SFR_BYTES];
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] wByte;

  assign rdByte  = strobe.toSfr ? sfr[strobe.addr[SFR_IDX_W-1:0]] : ram[strobe.addr];
  assign oldBit  = rdByte[strobe.bitIdx];
  assign bitMask = DATA_W'(1) << strobe.bitIdx;
  assign wByte   = strobe.isBit
                 ? ((rdByte & ~bitMask) | ({DATA_W{strobe.newBit}} & bitMask))
                 : strobe.wdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
      for (int i = 0; i < SFR_BYTES; i++) sfr[i] <= '0;
    end else if (strobe.wr) begin
      if (strobe.toSfr) sfr[strobe.addr[SFR_IDX_W-1:0]] <= wByte;
      else              ram[strobe.addr] <= wByte;
    end
  end

  // checker state: remembers the last bit write
  logic              lastBitWr;
  logic              lastSfr;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastByte;
  logic [DATA_W-1:0] lastMask;
  logic              lastNew;
  logic [DATA_W-1:0] tgtNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastBitWr <= 1'b0; lastSfr <= 1'b0; lastAddr <= '0;
      lastByte  <= '0;   lastMask <= '0;  lastNew <= 1'b0;
    end else begin
      lastBitWr <= strobe.wr && strobe.isBit;
      lastSfr   <= strobe.toSfr;
      lastAddr  <= strobe.addr;
      lastByte  <= rdByte;
      lastMask  <= bitMask;
      lastNew   <= strobe.newBit;
    end
  end

  assign tgtNow = lastSfr ? sfr[lastAddr[SFR_IDX_W-1:0]] : ram[lastAddr];

  AST_BIT_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    lastBitWr |-> (((tgtNow ^ lastByte) & ~lastMask) == '0)); // R8
  AST_BIT_NEW_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    lastBitWr |-> (((tgtNow & lastMask) != '0) == lastNew)); // R7
  AST_SFR_NONBIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && strobe.toSfr && strobe.isBit) |-> SFR_BIT_MASK[strobe.addr[6:3]]); // R9
  AST_SFR_BIT_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.toSfr && strobe.isBit) |-> (strobe.addr[2:0] == 3'b000 && strobe.addr[7])); // R6
endmodule

// File: rtl/bitram_unit.sv
module bitram_unit
  import bitram_pkg::*;
#(
  parameter int          RAM_BYTES    = 256,
  parameter int          SFR_BYTES    = 128,
  parameter int          BANK_SEL_W   = 2,
  parameter int          REG_IDX_W    = 3,
  parameter logic [15:0] SFR_BIT_MASK = 16'h7FFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteEn,
  input  logic                  byteWe,
  input  logic                  byteInd,
  input  logic [ADDR_W-1:0]     byteAddr,
  input  logic [DATA_W-1:0]     byteWdata,
  output logic [DATA_W-1:0]     byteRdata,
  input  logic                  regEn,
  input  logic                  regWe,
  input  logic [REG_IDX_W-1:0]  regIdx,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic                  bitEn,
  input  logic [2:0]            bitOp,
  input  logic [ADDR_W-1:0]     bitAddr,
  input  logic                  bitIn,
  output logic                  bitOut
);
  localparam int BANK_SPAN = (1 << BANK_SEL_W) * (1 << REG_IDX_W);

  memStrobeT         strobe;
  logic [DATA_W-1:0] rdByte;
  logic              oldBit;
  logic              bitOk;

  bitram_ctrl #(
    .BANK_SEL_W(BANK_SEL_W), .REG_IDX_W(REG_IDX_W),
    .BIT_AREA(8'(BANK_SPAN)), .SFR_BIT_MASK(SFR_BIT_MASK)
  ) ctrl (
    .byteEn(byteEn), .byteWe(byteWe), .byteInd(byteInd), .byteAddr(byteAddr),
    .byteWdata(byteWdata), .regEn(regEn), .regWe(regWe), .regIdx(regIdx),
    .bankSel(bankSel), .regWdata(regWdata), .bitEn(bitEn), .bitOp(bitOp),
    .bitAddr(bitAddr), .bitIn(bitIn), .oldBit(oldBit), .strobe(strobe), .bitOk(bitOk)
  );

  bitram_dp #(
    .RAM_BYTES(RAM_BYTES), .SFR_BYTES(SFR_BYTES), .SFR_BIT_MASK(SFR_BIT_MASK)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdByte(rdByte), .oldBit(oldBit)
  );

  assign byteRdata = byteEn ? rdByte : '0;
  assign regRdata  = regEn  ? rdByte : '0;
  assign bitOut    = bitEn && bitOk && oldBit;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({byteEn, regEn, bitEn})); // R8
  AST_IND_HITS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn && byteInd) |-> !strobe.toSfr); // R4
  AST_REG_IN_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    regEn |-> (int'(strobe.addr) < BANK_SPAN && !strobe.toSfr)); // R2
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !byteEn |-> (byteRdata == '0)); // R10
endmodule

// File: tb/tb_bitram_unit.sv
module tb_bitram_unit;
  localparam int PERIOD = 10;
  localparam int NV = 30;
  // {kind[30:29], we[28], op[27:25], bitIn[24], addr[23:16], wdata[15:8], exp[7:0]}
  // kind: 0 byte direct, 1 byte indirect, 2 working register (addr[4:3]=bank, addr[2:0]=idx), 3 bit
  localparam logic [30:0] VEC [NV] = '{
    {2'd0,1'b1,3'd0,1'b0,8'h13,8'hA5,8'h00}, // R3 write 13h
    {2'd2,1'b0,3'd0,1'b0,8'h13,8'h00,8'hA5}, // R2 bank2 idx3
    {2'd2,1'b1,3'd0,1'b0,8'h1F,8'h3C,8'h00}, // R2 bank3 idx7 write
    {2'd1,1'b0,3'd0,1'b0,8'h1F,8'h00,8'h3C}, // R3 indirect read
    {2'd0,1'b1,3'd0,1'b0,8'h90,8'h55,8'h00}, // R4 SFR write
    {2'd1,1'b1,3'd0,1'b0,8'h90,8'hAA,8'h00}, // R4 upper RAM write
    {2'd0,1'b0,3'd0,1'b0,8'h90,8'h00,8'h55}, // R4
    {2'd1,1'b0,3'd0,1'b0,8'h90,8'h00,8'hAA}, // R4
    {2'd3,1'b0,3'd5,1'b0,8'h2B,8'h00,8'h00}, // R5 set 25h.3
    {2'd0,1'b0,3'd0,1'b0,8'h25,8'h00,8'h08}, // R5
    {2'd0,1'b1,3'd0,1'b0,8'h21,8'hF0,8'h00}, // R5
    {2'd3,1'b0,3'd6,1'b0,8'h0C,8'h00,8'h01}, // R7 move 0
    {2'd0,1'b0,3'd0,1'b0,8'h21,8'h00,8'hE0}, // R8
    {2'd3,1'b0,3'd3,1'b1,8'h08,8'h00,8'h00}, // R7 xor
    {2'd3,1'b0,3'd2,1'b0,8'h0F,8'h00,8'h01}, // R7 and
    {2'd3,1'b0,3'd1,1'b1,8'h0D,8'h00,8'h01}, // R7 or
    {2'd3,1'b0,3'd4,1'b0,8'h09,8'h00,8'h00}, // R7 cpl
    {2'd0,1'b0,3'd0,1'b0,8'h21,8'h00,8'h63}, // R8
    {2'd3,1'b0,3'd7,1'b0,8'h09,8'h00,8'h01}, // R7 test-clear
    {2'd3,1'b0,3'd7,1'b0,8'h09,8'h00,8'h00}, // R7 test-clear again
    {2'd3,1'b0,3'd5,1'b0,8'h94,8'h00,8'h01}, // R6 set already set
    {2'd3,1'b0,3'd6,1'b1,8'h97,8'h00,8'h00}, // R6 move 1
    {2'd0,1'b0,3'd0,1'b0,8'h90,8'h00,8'hD5}, // R6
    {2'd1,1'b0,3'd0,1'b0,8'h90,8'h00,8'hAA}, // R4 upper RAM untouched
    {2'd3,1'b0,3'd0,1'b0,8'h96,8'h00,8'h01}, // R6 read
    {2'd0,1'b1,3'd0,1'b0,8'hF8,8'hFF,8'h00}, // R9 setup
    {2'd3,1'b0,3'd0,1'b0,8'hFB,8'h00,8'h00}, // R9 reads 0
    {2'd3,1'b0,3'd4,1'b0,8'hF8,8'h00,8'h00}, // R9 cpl ignored
    {2'd0,1'b0,3'd0,1'b0,8'hF8,8'h00,8'hFF}, // R9
    {2'd0,1'b0,3'd0,1'b0,8'h21,8'h00,8'h61}  // R8
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic byteEn = 0, byteWe = 0, byteInd = 0, regEn = 0, regWe = 0, bitEn = 0, bitIn = 0;
  logic [7:0] byteAddr = 0, byteWdata = 0, regWdata = 0, bitAddr = 0;
  logic [2:0] regIdx = 0, bitOp = 0;
  logic [1:0] bankSel = 0;
  logic [7:0] byteRdata, regRdata;
  logic bitOut;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bitram_unit dut (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .byteWe(byteWe), .byteInd(byteInd),
    .byteAddr(byteAddr), .byteWdata(byteWdata), .byteRdata(byteRdata),
    .regEn(regEn), .regWe(regWe), .regIdx(regIdx), .bankSel(bankSel),
    .regWdata(regWdata), .regRdata(regRdata), .bitEn(bitEn), .bitOp(bitOp),
    .bitAddr(bitAddr), .bitIn(bitIn), .bitOut(bitOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    byteEn = 0; byteWe = 0; regEn = 0; regWe = 0; bitEn = 0;
  endtask

  // one access: drive after negedge, sample before the next rising edge
  task automatic access(input logic [30:0] v, input string req);
    logic [7:0] act;
    @(negedge clk);
    idle();
    unique case (v[30:29])
      2'd0, 2'd1: begin
        byteEn = 1; byteInd = v[29]; byteWe = v[28];
        byteAddr = v[23:16]; byteWdata = v[15:8];
      end
      2'd2: begin
        regEn = 1; regWe = v[28]; bankSel = v[20:19]; regIdx = v[18:16];
        bankSel = v[20:19] ^ 2'b00; regWdata = v[15:8];
      end
      default: begin
        bitEn = 1; bitOp = v[27:25]; bitIn = v[24]; bitAddr = v[23:16];
      end
    endcase
    #1;
    act = (v[30:29] == 2'd3) ? {7'd0, bitOut} : (v[30:29] == 2'd2) ? regRdata : byteRdata;
    check(req, act, v[7:0]);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    access({2'd0,1'b0,3'd0,1'b0,8'h21,8'h00,8'h00}, "R1");
    access({2'd0,1'b0,3'd0,1'b0,8'hD0,8'h00,8'h00}, "R1");
    access({2'd1,1'b0,3'd0,1'b0,8'hFF,8'h00,8'h00}, "R1");
    for (int i = 0; i < NV; i++) access(VEC[i], $sformatf("vector %0d", i));
    // R3: bank byte reachable whatever bankSel holds
    @(negedge clk); idle(); byteEn = 1; byteInd = 0; byteAddr = 8'h13; bankSel = 2'd0;
    #1 check("R3", byteRdata, 8'hA5);
    // R10: outputs quiet when port idle
    @(negedge clk); idle(); byteAddr = 8'h13; regIdx = 3'd3; bankSel = 2'd2;
    #1 check("R10", byteRdata, 8'h00);
    check("R10", regRdata, 8'h00);
    // R2 bank 0 vs bank 3 distinct
    access({2'd2,1'b1,3'd0,1'b0,8'h07,8'h77,8'h00}, "R2");
    access({2'd0,1'b0,3'd0,1'b0,8'h07,8'h00,8'h77}, "R2");
    access({2'd2,1'b0,3'd0,1'b0,8'h1F,8'h00,8'h3C}, "R2");
    // R1 reset again clears contents
    @(negedge clk); idle(); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access({2'd0,1'b0,3'd0,1'b0,8'h21,8'h00,8'h00}, "R1");
    access({2'd0,1'b0,3'd0,1'b0,8'h90,8'h00,8'h00}, "R1");
    @(negedge clk); idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule